// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a two-level logic array whose function is set at run time. A row of AND terms sits in front of a row of OR gates, and both rows can be programmed. Each AND term can take any input in its true form, its inverted form, or not at all. Each OR output can collect any set of AND terms. One AND term may feed several outputs at once, so logic that several outputs have in common is built only once.

The setting is held in a single serial shift chain. The chain has its own clock, an enable and an active-low asynchronous clear. A controller loads it by holding the enable high and feeding one bit per configuration clock, most significant bit first. While the enable is high the outputs may change freely. Once the enable drops, the stored setting stays fixed. The path from the data inputs to the outputs is purely combinational and has no clock in it.

The default size is 4 inputs, 8 AND terms and 4 outputs. This gives a 96-bit chain.

Top module: `sop_logic_array`

## Requirements
- R1: While `cfg_rst_n` is low, the chain holds all zeros. Every output and `cfg_dout` then read 0 for every input value.
- R2: On each rising `cfg_clk` edge with `cfg_en` high, the chain moves one place toward its top bit and takes `cfg_din` into bit 0. `cfg_dout` always shows the top bit, so after a full load of CFG_W bits the first bit shifted in is on `cfg_dout`.
- R3: While `cfg_en` is low, `cfg_clk` edges leave the chain unchanged, whatever `cfg_din` does. Both `cfg_dout` and the logic function stay the same.
- R4: AND-plane layout. Chain bit t*2N+2i includes the true form of input i in term t. Chain bit t*2N+2i+1 includes the inverted form of input i in term t. A term is the AND of the forms it includes.
- R5: A term that includes no literal evaluates to 0.
- R6: OR-plane layout. Chain bit 2NP+o*P+t connects term t to output o. Each output is the OR of the terms connected to it, and an output with no terms connected reads 0.
- R7: One term connected to several outputs drives all of them.
- R8: Outputs follow changes on `in_vec` without any `cfg_clk` edge.
- R9: A term that includes both forms of the same input evaluates to 0 for every input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_rst_n | input | 1 | Asynchronous clear of the chain, active low |
| cfg_en | input | 1 | Shift enable for the chain |
| cfg_din | input | 1 | Serial configuration bit in |
| cfg_dout | output | 1 | Top bit of the chain |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
The assertions assume that `cfg_rst_n` is driven low at time zero. They also assume that `cfg_din` and `cfg_en` are driven to known values around every configuration clock edge, and that `in_vec` is never unknown. The bench meets these by setting every input at time zero and by changing inputs only on the falling clock edge. Outputs are sampled only after `cfg_en` has dropped, because the logic function is undefined during a load. Random settings use sparse AND-plane bits, so that many terms are non-trivial and do not collapse to 0.

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4
) (
  input  logic              cfg_clk,
  input  logic              cfg_rst_n,
  input  logic              cfg_en,
  input  logic              cfg_din,
  output logic              cfg_dout,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);
  localparam int LIT_W = 2 * N_IN;
  localparam int AND_W = N_TERM * LIT_W;
  localparam int OR_W  = N_OUT * N_TERM;
  localparam int CFG_W = AND_W + OR_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [LIT_W-1:0]  lits;
  logic [N_TERM-1:0] term;

  always_ff @(posedge cfg_clk or negedge cfg_rst_n)
    if (!cfg_rst_n)  cfg_q <= '0;
    else if (cfg_en) cfg_q <= {cfg_q[CFG_W-2:0], cfg_din};

  assign cfg_dout = cfg_q[CFG_W-1];

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = in_vec[i];
    assign lits[2*i+1] = ~in_vec[i];
  end

  // AND plane: an empty mask yields 0, otherwise all selected literals must be 1
  for (genvar t = 0; t < N_TERM; t++) begin : g_and
    logic [LIT_W-1:0] mask;
    assign mask    = cfg_q[t*LIT_W +: LIT_W];
    assign term[t] = (|mask) & (&(lits | ~mask));

    always_comb begin
      if (cfg_rst_n && mask == '0)
        assert_idle_term_R5: assert (term[t] == 1'b0);
      for (int i = 0; i < N_IN; i++)
        if (cfg_rst_n && mask[2*i] && mask[2*i+1])
          assert_contra_term_R9: assert (term[t] == 1'b0);
    end
  end

  // OR plane: each output row picks any subset of the shared terms
  for (genvar o = 0; o < N_OUT; o++) begin : g_or
    logic [N_TERM-1:0] row;
    assign row        = cfg_q[AND_W + o*N_TERM +: N_TERM];
    assign out_vec[o] = |(row & term);

    always_comb
      if (cfg_rst_n && row == '0)
        assert_empty_row_R6: assert (out_vec[o] == 1'b0);
  end

  always_comb
    if (!cfg_rst_n)
      assert_clear_R1: assert (out_vec == '0 && cfg_dout == 1'b0);

  assert_shift_R2: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    cfg_en |=> cfg_dout == $past(cfg_q[CFG_W-2]));

  assert_hold_R3: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !cfg_en |=> $stable(cfg_dout));
endmodule

// File: tb/sop_logic_array_test.sv
module sop_logic_array_test;
  localparam int N = 4, P = 8, M = 4;
  localparam int AW = P * 2 * N;
  localparam int CW = AW + M * P;

  logic cfg_clk = 1'b0, cfg_rst_n = 1'b0, cfg_en = 1'b0, cfg_din = 1'b0;
  logic cfg_dout;
  logic [N-1:0] in_vec = '0;
  logic [M-1:0] out_vec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 cfg_clk = ~cfg_clk;

  sop_logic_array #(.N_IN(N), .N_TERM(P), .N_OUT(M)) uut (
    .cfg_clk(cfg_clk), .cfg_rst_n(cfg_rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .in_vec(in_vec), .out_vec(out_vec));

  function automatic logic [M-1:0] model(logic [CW-1:0] c, logic [N-1:0] x);
    logic [M-1:0] r = '0;
    for (int o = 0; o < M; o++)
      for (int t = 0; t < P; t++) begin
        logic any = 0, prod = 1;
        for (int i = 0; i < N; i++) begin
          if (c[t*2*N + 2*i])   begin any = 1; prod &= x[i];  end
          if (c[t*2*N + 2*i+1]) begin any = 1; prod &= ~x[i]; end
        end
        if (c[AW + o*P + t] && any && prod) r[o] = 1'b1;
      end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(logic [CW-1:0] v);
    for (int k = CW-1; k >= 0; k--) begin
      @(negedge cfg_clk);
      cfg_en = 1'b1; cfg_din = v[k];
    end
    @(negedge cfg_clk);
    cfg_en = 1'b0; cfg_din = 1'b0;
  endtask

  task automatic sweep(logic [CW-1:0] c, string req);
    for (int x = 0; x < (1 << N); x++) begin
      in_vec = x[N-1:0];
      #1;
      check(out_vec === model(c, in_vec), req, out_vec, model(c, in_vec));
    end
  endtask

  initial begin : main
    logic [CW-1:0] cfg;
    logic [M-1:0] snap;
    void'($urandom(32'd20240611));

    // R1: cleared chain while reset is held
    for (int x = 0; x < (1 << N); x++) begin
      in_vec = x[N-1:0]; #1;
      check(out_vec === '0, "R1", out_vec, 0);
    end
    check(cfg_dout === 1'b0, "R1", cfg_dout, 0);
    repeat (3) @(negedge cfg_clk);
    cfg_rst_n = 1'b1;

    // R5 / R6: all-zero setting
    load('0);
    sweep('0, "R5");

    // R4 / R7: term 0 = in0 & ~in2, shared by every output
    cfg = '0;
    cfg[0] = 1'b1; cfg[5] = 1'b1;
    for (int o = 0; o < M; o++) cfg[AW + o*P] = 1'b1;
    load(cfg);
    sweep(cfg, "R7");
    in_vec = 4'b0001; #1;
    check(out_vec === '1, "R4", out_vec, 4'hf);

    // R9: term 1 holds both forms of input 1, routed to output 2
    cfg = '0;
    cfg[1*2*N + 2] = 1'b1; cfg[1*2*N + 3] = 1'b1;
    cfg[AW + 2*P + 1] = 1'b1;
    load(cfg);
    sweep(cfg, "R9");

    // R2: chain output after a full load, then one extra shift
    cfg = '0;
    cfg[CW-1] = 1'b1; cfg[CW-2] = 1'b0;
    load(cfg);
    check(cfg_dout === 1'b1, "R2", cfg_dout, 1);
    @(negedge cfg_clk); cfg_en = 1'b1; cfg_din = 1'b0;
    @(negedge cfg_clk); cfg_en = 1'b0;
    check(cfg_dout === 1'b0, "R2", cfg_dout, 0);

    // R3: toggling data with enable low leaves the function alone
    cfg = '0;
    cfg[2] = 1'b1; cfg[AW + 1*P] = 1'b1; cfg[CW-1] = 1'b1;
    load(cfg);
    for (int n = 0; n < 20; n++) begin
      @(negedge cfg_clk); cfg_din = n[0];
    end
    cfg_din = 1'b0;
    check(cfg_dout === 1'b1, "R3", cfg_dout, 1);
    sweep(cfg, "R3");

    // R8: output follows input with no clock edge
    @(negedge cfg_clk);
    #0.5 in_vec = 4'b0010; #0.5;
    check(out_vec === model(cfg, 4'b0010), "R8", out_vec, model(cfg, 4'b0010));
    snap = out_vec;
    in_vec = 4'b0000; #0.5;
    check(out_vec !== snap && out_vec === model(cfg, 4'b0000), "R8", out_vec, model(cfg, 4'b0000));

    // R4 / R6: random sparse settings swept over every input
    for (int r = 0; r < 40; r++) begin
      for (int k = 0; k < CW; k++)
        cfg[k] = (k < AW) ? ($urandom % 4 == 0) : ($urandom % 2 == 1);
      load(cfg);
      sweep(cfg, "R6");
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule